// File: doc/BRIEF.md
# Per-Chip-Select Data Wait Generator

This block sits in an external bus controller and decides how long each external access cycle is stretched. Eight chip-select areas each own a 3-bit wait code. The codes live in two 16-bit control words, four codes per word, with one unused bit between neighbouring codes. Software reaches the words through a simple word-wide register port. After reset every area is set to the longest stretch, so slow devices work before software has configured anything.

When the bus sequencer starts an access, it gives the block the decoded area number and two qualifiers. One says the target is on-chip memory. The other says the access is an on-page hit of a page-mode ROM, which comes with its own externally supplied wait code. The block picks the applicable wait count and latches it. It then inserts that many wait cycles after the first access state before it signals that the data state completes. Changing a register during an access cannot disturb the access already running.

Top module: `cs_wait_gen`

## Requirements
- R1: The control word for areas 0 to 3 is at register offset 0xF484 and the word for areas 4 to 7 is at 0xFFE0. Both are read and written only as whole 16-bit words. Any other offset reads as 0x0000, and a write to it changes no stored code.
- R2: The code of area k occupies bits [4m+2:4m] of its word, where m = k mod 4. Bits 3, 7, 11 and 15 always read 0, and writing ones to them has no effect.
- R3: A code value N from 0 to 7 inserts exactly N wait cycles. 7 is the largest possible stretch.
- R4: The cycle in which acc_start is accepted is the first state T1. In the next N cycles acc_wait is 1 and acc_ready is 0. In the cycle after that, acc_ready is 1 for exactly one cycle. acc_ready and acc_wait are never 1 together.
- R5: After reset both control words read 0x7777, so every area waits 7 cycles.
- R6: When acc_internal is 1, the access gets zero wait cycles whatever the stored codes, the page flag and page_wait are.
- R7: When acc_page_hit is 1 and acc_internal is 0, the wait count is page_wait, not the area's stored code. acc_internal takes priority over acc_page_hit.
- R8: The wait count is captured in T1. A register write during the access does not change its length, and the write itself takes effect.
- R9: acc_start is ignored while an access is in progress, including its acc_ready cycle. A new access is accepted in the cycle right after acc_ready. While idle, acc_ready and acc_wait are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Word write strobe for the register port |
| reg_addr | input | 16 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| acc_start | input | 1 | Access start, marks T1 |
| acc_cs | input | 3 | Decoded chip-select area of the access |
| acc_internal | input | 1 | Access targets on-chip memory |
| acc_page_hit | input | 1 | Page-ROM on-page access |
| page_wait | input | 3 | Wait count to use for on-page accesses |
| acc_wait | output | 1 | Access stretched (wait state) |
| acc_ready | output | 1 | Data state completes in this cycle |

## Verification
The checker examines some properties on every cycle. Reserved read bits are always zero. Ready and wait never overlap. A wait run never exceeds seven cycles and always ends in a ready cycle. The ready cycle is always followed by idle outputs. Internal accesses, and on-page accesses with a zero page code, complete in the cycle after T1. Only the bench's scenarios can show that the length of each stretch matches the code stored for the selected area. It sweeps every area across all eight code values and checks the field packing by reading the words back. It also covers the reset defaults, the choice between page and area codes, and the way a mid-access write and an ignored mid-access start leave the running count unchanged.

// File: rtl/cswg_pkg.sv
package cswg_pkg;
  parameter int CS_NUM  = 8;
  parameter int CODE_W  = 3;
  parameter int REG_W   = 16;
  parameter int ADDR_W  = 16;
  localparam int FLD_STRIDE = CODE_W + 1;
  localparam int CS_IDX_W   = $clog2(CS_NUM);

  typedef enum logic {
    CTR_IDLE = 1'b0,
    CTR_RUN  = 1'b1
  } ctr_state_t;
endpackage

// File: rtl/cswg_regfile.sv
module cswg_regfile #(
  parameter int NCS    = 8,
  parameter int CODE_W = 3,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] OFS_LO = 16'hF484,
  parameter logic [ADDR_W-1:0] OFS_HI = 16'hFFE0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rdata,
  output logic [NCS*CODE_W-1:0] codes
);
  localparam int STRIDE = CODE_W + 1;
  localparam int FPR    = REG_W / STRIDE;
  localparam int NREG   = NCS / FPR;

  logic [NREG-1:0]       hit;
  logic [NCS*CODE_W-1:0] codes_q;
  logic [NCS*CODE_W-1:0] codes_d;
  logic [REG_W-1:0]      rsv_mask;
  logic                  unused_rsv;

  for (genvar r = 0; r < NREG; r++) begin : g_hit
    assign hit[r] = (addr == ((r == 0) ? OFS_LO : OFS_HI));
  end

  always_comb begin
    rsv_mask = '0;
    for (int b = 0; b < REG_W; b++) begin
      if ((b % STRIDE) == CODE_W) rsv_mask[b] = 1'b1;
    end
  end
  assign unused_rsv = ^(wdata & rsv_mask);

  always_comb begin
    codes_d = codes_q;
    for (int k = 0; k < NCS; k++) begin
      if (wr_en && hit[k / FPR]) begin
        codes_d[k*CODE_W +: CODE_W] = wdata[(k % FPR)*STRIDE +: CODE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codes_q <= '1;
    end else if (wr_en) begin
      codes_q <= codes_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NCS; k++) begin
      if (hit[k / FPR]) begin
        rdata[(k % FPR)*STRIDE +: CODE_W] = codes_q[k*CODE_W +: CODE_W];
      end
    end
  end

  assign codes = codes_q;
endmodule

// File: rtl/cswg_wait_sel.sv
module cswg_wait_sel #(
  parameter int NCS    = 8,
  parameter int CODE_W = 3,
  localparam int IDX_W = $clog2(NCS)
) (
  input  logic [NCS*CODE_W-1:0] codes,
  input  logic [IDX_W-1:0]      cs,
  input  logic                  internal,
  input  logic                  page_hit,
  input  logic [CODE_W-1:0]     page_code,
  output logic [CODE_W-1:0]     sel_code
);
  always_comb begin
    if (internal) begin
      sel_code = '0;
    end else if (page_hit) begin
      sel_code = page_code;
    end else begin
      sel_code = codes[cs*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/cswg_wait_ctr.sv
module cswg_wait_ctr
  import cswg_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] target,
  output logic              busy,
  output logic              wait_o,
  output logic              ready_o
);
  ctr_state_t        st_q, st_d;
  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic [CODE_W-1:0] tgt_q, tgt_d;
  logic              done;
  logic              en;

  assign done = (st_q == CTR_RUN) && (cnt_q == tgt_q);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    tgt_d = tgt_q;
    en    = 1'b0;
    case (st_q)
      CTR_IDLE: begin
        if (start) begin
          st_d  = CTR_RUN;
          cnt_d = '0;
          tgt_d = target;
          en    = 1'b1;
        end
      end
      CTR_RUN: begin
        en = 1'b1;
        if (done) begin
          st_d = CTR_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d = CTR_IDLE;
        en   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CTR_IDLE;
      cnt_q <= '0;
      tgt_q <= '0;
    end else if (en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
    end
  end

  assign busy    = (st_q == CTR_RUN);
  assign ready_o = done;
  assign wait_o  = busy && !done;
endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
  import cswg_pkg::*;
#(
  parameter int NCS    = cswg_pkg::CS_NUM,
  parameter int CODE_W = cswg_pkg::CODE_W,
  parameter int REG_W  = cswg_pkg::REG_W,
  parameter int ADDR_W = cswg_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] OFS_LO = 16'hF484,
  parameter logic [ADDR_W-1:0] OFS_HI = 16'hFFE0,
  localparam int IDX_W = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              acc_start,
  input  logic [IDX_W-1:0]  acc_cs,
  input  logic              acc_internal,
  input  logic              acc_page_hit,
  input  logic [CODE_W-1:0] page_wait,
  output logic              acc_wait,
  output logic              acc_ready
);
  logic [NCS*CODE_W-1:0] codes;
  logic [CODE_W-1:0]     sel_code;
  logic                  ctr_busy;

  cswg_regfile #(
    .NCS(NCS), .CODE_W(CODE_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .OFS_LO(OFS_LO), .OFS_HI(OFS_HI)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .codes (codes)
  );

  cswg_wait_sel #(.NCS(NCS), .CODE_W(CODE_W)) u_sel (
    .codes     (codes),
    .cs        (acc_cs),
    .internal  (acc_internal),
    .page_hit  (acc_page_hit),
    .page_code (page_wait),
    .sel_code  (sel_code)
  );

  cswg_wait_ctr #(.CODE_W(CODE_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (acc_start),
    .target  (sel_code),
    .busy    (ctr_busy),
    .wait_o  (acc_wait),
    .ready_o (acc_ready)
  );
endmodule

// File: rtl/cswg_chk.sv
module cswg_chk #(
  parameter int CODE_W = 3,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_start,
  input logic              acc_internal,
  input logic              acc_page_hit,
  input logic [CODE_W-1:0] page_wait,
  input logic              acc_wait,
  input logic              acc_ready,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              busy
);
  localparam int STRIDE = CODE_W + 1;
  localparam int MAXW   = (1 << CODE_W) - 1;

  logic [REG_W-1:0] rsv_mask;
  logic [CODE_W:0]  run_q;

  always_comb begin
    rsv_mask = '0;
    for (int b = 0; b < REG_W; b++) begin
      if ((b % STRIDE) == CODE_W) rsv_mask[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (acc_wait) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & rsv_mask) == '0);

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ready && acc_wait));

  // R4
  wait_ends_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wait |=> (acc_wait || acc_ready));

  // R3
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wait |-> (run_q < MAXW));

  // R9
  ready_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |=> (!acc_ready && !acc_wait));

  // R6
  internal_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !busy && acc_internal) |=> acc_ready);

  // R7
  page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !busy && !acc_internal && acc_page_hit && page_wait == '0)
      |=> acc_ready);
endmodule

bind cs_wait_gen cswg_chk #(.CODE_W(CODE_W), .REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_start    (acc_start),
  .acc_internal (acc_internal),
  .acc_page_hit (acc_page_hit),
  .page_wait    (page_wait),
  .acc_wait     (acc_wait),
  .acc_ready    (acc_ready),
  .reg_rdata    (reg_rdata),
  .busy         (ctr_busy)
);

// File: tb/cs_wait_gen_bench.sv
`timescale 1ns/1ps
module cs_wait_gen_bench;
  localparam time HALF = 10ns;
  localparam logic [15:0] A_LO = 16'hF484;
  localparam logic [15:0] A_HI = 16'hFFE0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [15:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        acc_start;
  logic [2:0]  acc_cs;
  logic        acc_internal;
  logic        acc_page_hit;
  logic [2:0]  page_wait;
  logic        acc_wait;
  logic        acc_ready;

  int n_chk = 0;
  int n_fail = 0;

  always #HALF clk = ~clk;

  cs_wait_gen u_cs_wait_gen (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .acc_start(acc_start), .acc_cs(acc_cs), .acc_internal(acc_internal),
    .acc_page_hit(acc_page_hit), .page_wait(page_wait),
    .acc_wait(acc_wait), .acc_ready(acc_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [15:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  // Runs one access from the current falling edge; mid_wr writes 0 to the
  // low word in the first wait cycle, mid_st pulses an internal start in the second.
  task automatic run_acc(input int cs, input bit intl, input bit pg, input int pw,
                         input int exp, input bit mid_wr, input bit mid_st,
                         input string req);
    int n;
    acc_cs = 3'(cs); acc_internal = intl; acc_page_hit = pg; page_wait = 3'(pw);
    acc_start = 1'b1;
    @(negedge clk);
    acc_start = 1'b0;
    n = 0;
    while (acc_wait && n < 20) begin
      n++;
      reg_wr_en = mid_wr && (n == 1); reg_addr = A_LO; reg_wdata = 16'h0000;
      acc_start = mid_st && (n == 2);
      acc_internal = mid_st ? 1'b1 : intl;
      @(negedge clk);
    end
    reg_wr_en = 1'b0; acc_start = 1'b0; acc_internal = intl;
    check(acc_ready && n == exp, req, n, exp);
    @(negedge clk);
    check(!acc_ready && !acc_wait, "R9 idle after ready", {acc_ready, acc_wait}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    acc_start = 1'b0; acc_cs = '0; acc_internal = 1'b0; acc_page_hit = 1'b0;
    page_wait = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 reset defaults, R1 unmapped offset
    rd_chk(A_LO, 16'h7777, "R5 low word reset");
    rd_chk(A_HI, 16'h7777, "R5 high word reset");
    rd_chk(16'hF486, 16'h0000, "R1 unmapped reads zero");
    check(!acc_ready && !acc_wait, "R9 idle outputs", {acc_ready, acc_wait}, 0);
    run_acc(3, 0, 0, 0, 7, 0, 0, "R5 default seven waits");

    // R1 write to an unmapped offset changes nothing
    wr(16'h1234, 16'h0000);
    rd_chk(A_LO, 16'h7777, "R1 stray write low");
    rd_chk(A_HI, 16'h7777, "R1 stray write high");

    // R2 R3 R4 sweep: area k gets code (k+p) mod 8, reserved bits written as ones
    for (int p = 0; p < 8; p++) begin
      logic [15:0] lo, hi;
      lo = 16'h8888; hi = 16'h8888;
      for (int m = 0; m < 4; m++) begin
        lo[4*m +: 3] = 3'((m + p) % 8);
        hi[4*m +: 3] = 3'((m + 4 + p) % 8);
      end
      wr(A_LO, lo);
      wr(A_HI, hi);
      rd_chk(A_LO, lo & 16'h7777, "R2 low word packing");
      rd_chk(A_HI, hi & 16'h7777, "R2 high word packing");
      for (int k = 0; k < 8; k++) begin
        run_acc(k, 0, 0, 0, (k + p) % 8, 0, 0, "R3 R4 area wait count");
      end
    end

    // R6 internal accesses, all areas at seven
    wr(A_LO, 16'h7777);
    wr(A_HI, 16'h7777);
    for (int k = 0; k < 8; k++) begin
      run_acc(k, 1, k[0], 5, 0, 0, 0, "R6 internal no waits");
    end

    // R7 page code overrides area code; internal wins over page
    for (int w = 0; w < 8; w++) begin
      run_acc(w, 0, 1, w, w, 0, 0, "R7 page wait used");
    end
    run_acc(2, 1, 1, 6, 0, 0, 0, "R7 internal over page");

    // R8 write during an access does not alter it, but lands
    wr(A_LO, 16'h0005);
    run_acc(0, 0, 0, 0, 5, 1, 0, "R8 latched count");
    rd_chk(A_LO, 16'h0000, "R8 mid-access write lands");

    // R9 start during an access is ignored
    wr(A_HI, 16'h0400);
    run_acc(6, 0, 0, 0, 4, 0, 1, "R9 start while busy ignored");
    run_acc(6, 0, 0, 0, 4, 0, 0, "R9 back-to-back start");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule